// File: doc/BRIEF.md
# Single-cycle modular adder-subtractor

This unit adds or subtracts two field elements modulo a fixed prime and delivers the reduced result one clock after a start strobe. Both operands must already lie in the range 0 to p−1. The prime and the operand width are parameters; the default is a 256-bit prime of the form 2^256 − 2^32 − 977.

The unit has two adders in series. The first forms the raw sum, or the raw difference as x plus the inverted y plus one. The second adder works on that raw value. In add mode it takes away p by adding the inverted prime with a carry-in of one. In subtract mode it adds p back. The carry bits of the two adders pick which of the two values is kept, so no magnitude comparator is built. The chosen value is captured in an output register, and a done pulse appears with it.

A datapath sequencer uses the unit for field operations that take one cycle. It raises start together with the operands and the mode, and reads the result on the cycle in which done is high.

Top module: `modas_top`

## Requirements
- R1: With op_sub = 0 (add), the result presented with done equals (x + y) mod p and is always below p.
- R2: With op_sub = 1 (subtract), the result presented with done equals (x − y) mod p and is always below p.
- R3: In add mode a sum at or above p is reduced by exactly one p: x = y = p−1 gives p−2, and x + y = p gives 0.
- R4: In subtract mode a negative difference gets p added back: x = 0, y = p−1 gives 1, x = 0, y = 1 gives p−1, and x = y gives 0.
- R5: An operation sampled with start at a rising edge shows its result and done = 1 right after that edge, for exactly one cycle. Starts on consecutive cycles give results on consecutive cycles.
- R6: While start is low, done stays 0 and result keeps its last value, whatever x_in, y_in and op_sub do.
- R7: After a synchronous active-high reset, done is 0 and result is 0.
- R8: op_sub encodes the mode: 0 selects addition and 1 selects subtraction. It is sampled in the same cycle as start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation on the current operands |
| op_sub | input | 1 | Mode: 0 add, 1 subtract |
| x_in | input | WIDTH | First operand, reduced below p |
| y_in | input | WIDTH | Second operand, reduced below p |
| result | output | WIDTH | Registered reduced result |
| done | output | 1 | One-cycle pulse marking a valid result |

## Verification
The bench builds two copies of the unit. The first keeps the default 256-bit width and prime. Directed operands near 0, near p−1 and near 2^256 exercise the carry out of the top bit of the raw sum and the wrap of the corrected value. The second copy uses a 5-bit width with p = 29. Every operand pair in both modes fits in a few thousand cycles, so each combination of the two carry bits is driven exhaustively, including sums that exceed 2^WIDTH.

// File: rtl/modas_pkg.sv
package modas_pkg;
  typedef enum logic {
    MODE_ADD = 1'b0,
    MODE_SUB = 1'b1
  } modas_mode_e;
endpackage

// File: rtl/modas_cpa.sv
module modas_cpa #(
  parameter int WIDTH = 256
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int EXT = WIDTH + 1;
  logic [EXT-1:0] wide;

  always_comb begin
    wide = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
  end

  assign sum  = wide[WIDTH-1:0];
  assign cout = wide[EXT-1];
endmodule

// File: rtl/modas_select.sv
module modas_select
  import modas_pkg::*;
#(
  parameter int WIDTH = 256
) (
  input  modas_mode_e      mode,
  input  logic [WIDTH-1:0] raw_val,
  input  logic             raw_carry,
  input  logic [WIDTH-1:0] fix_val,
  input  logic             fix_carry,
  output logic [WIDTH-1:0] picked
);
  logic use_fix;

  always_comb begin
    if (mode == MODE_ADD) begin
      // the raw sum is at or above p when it overflowed the width or the subtraction of p did not borrow
      use_fix = raw_carry | fix_carry;
    end else begin
      // no carry out of x + ~y + 1 means y > x, so p has to be added back
      use_fix = ~raw_carry;
    end
    picked = use_fix ? fix_val : raw_val;
  end
endmodule

// File: rtl/modas_top.sv
module modas_top
  import modas_pkg::*;
#(
  parameter int WIDTH = 256,
  parameter logic [WIDTH-1:0] MODULUS =
    256'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFE_FFFFFC2F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             op_sub,
  input  logic [WIDTH-1:0] x_in,
  input  logic [WIDTH-1:0] y_in,
  output logic [WIDTH-1:0] result,
  output logic             done
);
  modas_mode_e      mode;
  logic [WIDTH-1:0] y_term;
  logic             raw_cin;
  logic [WIDTH-1:0] raw_val;
  logic             raw_carry;
  logic [WIDTH-1:0] p_term;
  logic             fix_cin;
  logic [WIDTH-1:0] fix_val;
  logic             fix_carry;
  logic [WIDTH-1:0] picked;

  assign mode    = modas_mode_e'(op_sub);
  assign y_term  = (mode == MODE_SUB) ? ~y_in : y_in;
  assign raw_cin = (mode == MODE_SUB);
  assign p_term  = (mode == MODE_SUB) ? MODULUS : ~MODULUS;
  assign fix_cin = (mode == MODE_ADD);

  modas_cpa #(.WIDTH(WIDTH)) u_raw (
    .a    (x_in),
    .b    (y_term),
    .cin  (raw_cin),
    .sum  (raw_val),
    .cout (raw_carry)
  );

  modas_cpa #(.WIDTH(WIDTH)) u_fix (
    .a    (raw_val),
    .b    (p_term),
    .cin  (fix_cin),
    .sum  (fix_val),
    .cout (fix_carry)
  );

  modas_select #(.WIDTH(WIDTH)) u_sel (
    .mode      (mode),
    .raw_val   (raw_val),
    .raw_carry (raw_carry),
    .fix_val   (fix_val),
    .fix_carry (fix_carry),
    .picked    (picked)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        result <= picked;
      end
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!done && result == '0)); // R7
  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (rst) start |=> done); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) !start |=> !done); // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst) !start |=> $stable(result)); // R6
  AST_RESULT_REDUCED: assert property (@(posedge clk) disable iff (rst) done |-> (result < MODULUS)); // R1
endmodule

// File: tb/modas_top_test.sv
module modas_top_test;
  localparam int W = 256;
  localparam logic [W-1:0] P =
    256'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFE_FFFFFC2F;
  localparam int SW = 5;
  localparam logic [SW-1:0] SP = 5'd29;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          start, op_sub;
  logic [W-1:0]  x_in, y_in, result;
  logic          done;
  logic          s_start, s_op;
  logic [SW-1:0] s_x, s_y, s_result;
  logic          s_done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  modas_top uut (
    .clk(clk), .rst(rst), .start(start), .op_sub(op_sub),
    .x_in(x_in), .y_in(y_in), .result(result), .done(done)
  );

  modas_top #(.WIDTH(SW), .MODULUS(SP)) uut_small (
    .clk(clk), .rst(rst), .start(s_start), .op_sub(s_op),
    .x_in(s_x), .y_in(s_y), .result(s_result), .done(s_done)
  );

  function automatic logic [W-1:0] ref256(input logic sub, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W:0] t;
    if (!sub) begin
      t = {1'b0, a} + {1'b0, b};
      if (t >= {1'b0, P}) t = t - {1'b0, P};
    end else begin
      if (a >= b) t = {1'b0, a} - {1'b0, b};
      else t = {1'b0, a} + {1'b0, P} - {1'b0, b};
    end
    return t[W-1:0];
  endfunction

  task automatic check256(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic op256(input string req, input logic sub, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] exp);
    @(negedge clk);
    start = 1'b1; op_sub = sub; x_in = a; y_in = b;
    @(negedge clk);
    start = 1'b0;
    check_bit({req, " done"}, done, 1'b1);
    check256(req, result, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check_bit("R7 done after reset", done, 1'b0);
    check256("R7 result after reset", result, '0);
  endtask

  task automatic t_corners;
    logic [W-1:0] half;
    half = P >> 1;
    op256("R3 add p-1 + p-1", 1'b0, P - 1, P - 1, P - 2);
    op256("R3 add sum equals p", 1'b0, P - 5, 5, '0);
    op256("R1 add small no wrap", 1'b0, 256'd12345, 256'd67890, 256'd80235);
    op256("R1 add half plus half", 1'b0, half, half + 1, ref256(1'b0, half, half + 1));
    op256("R1 add just below p", 1'b0, P - 3, 256'd1, P - 2);
    op256("R4 sub 0 - (p-1)", 1'b1, '0, P - 1, 256'd1);
    op256("R4 sub 0 - 1", 1'b1, '0, 256'd1, P - 1);
    op256("R4 sub x equals y", 1'b1, P - 7, P - 7, '0);
    op256("R2 sub p-1 - p-1", 1'b1, P - 1, P - 1, '0);
    op256("R2 sub positive", 1'b1, P - 1, 256'd3, P - 4);
    op256("R2 sub half mix", 1'b1, half, P - 2, ref256(1'b1, half, P - 2));
    op256("R8 mode 0 adds", 1'b0, 256'd9, 256'd4, 256'd13);
    op256("R8 mode 1 subtracts", 1'b1, 256'd9, 256'd4, 256'd5);
  endtask

  task automatic t_idle_hold;
    logic [W-1:0] held;
    op256("R6 setup", 1'b0, 256'd100, 256'd23, 256'd123);
    held = 256'd123;
    @(negedge clk);
    check_bit("R5 done is a single pulse", done, 1'b0);
    op_sub = 1'b1; x_in = P - 1; y_in = 256'd77;
    @(negedge clk);
    x_in = 256'd5; y_in = P - 9; op_sub = 1'b0;
    @(negedge clk);
    check_bit("R6 done low while idle", done, 1'b0);
    check256("R6 result held while idle", result, held);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    start = 1'b1; op_sub = 1'b0; x_in = P - 2; y_in = 256'd10;
    @(negedge clk);
    check_bit("R5 first done", done, 1'b1);
    check256("R5 first result", result, 256'd8);
    op_sub = 1'b1; x_in = 256'd2; y_in = 256'd10;
    @(negedge clk);
    start = 1'b0;
    check_bit("R5 second done", done, 1'b1);
    check256("R5 second result", result, P - 8);
    @(negedge clk);
    check_bit("R5 done drops after last start", done, 1'b0);
    check256("R6 result kept after last start", result, P - 8);
  endtask

  task automatic t_small_sweep;
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 29; a++) begin
        for (int b = 0; b < 29; b++) begin
          int e;
          e = (m == 0) ? (a + b) % 29 : (a - b + 29) % 29;
          @(negedge clk);
          s_start = 1'b1; s_op = m[0]; s_x = SW'(a); s_y = SW'(b);
          @(negedge clk);
          s_start = 1'b0;
          checks++;
          if (s_done !== 1'b1 || s_result !== SW'(e)) begin
            errors++;
            $display("FAIL %s small a=%0d b=%0d: actual=%0d done=%b expected=%0d",
                     (m == 0) ? "R1" : "R2", a, b, s_result, s_done, e);
          end
        end
      end
    end
  endtask

  initial begin
    start = 1'b0; op_sub = 1'b0; x_in = '0; y_in = '0;
    s_start = 1'b0; s_op = 1'b0; s_x = '0; s_y = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_corners();
    t_idle_hold();
    t_back_to_back();
    t_small_sweep();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule